// File: doc/BRIEF.md
# Unsigned Word Multiply Execute Unit

This block decodes and runs one instruction: an unsigned 32-bit by 32-bit multiply. It works against a local file of 32 general registers. An instruction word arrives with a one-cycle valid strobe. If the unit is idle and the word matches one of the two accepted encodings, it takes the operands and starts.

In the register form the second operand is another register. In the immediate form the second operand is a 9-bit constant, split across two fields of the word and zero-extended to 32 bits. The full 64-bit product is built by a shift-and-add sequence of 32 steps. The upper half goes to one destination register and the lower half goes back into the first source register. A done pulse marks the cycle in which both writes are committed.

A word that matches neither encoding raises an illegal pulse and changes nothing. A side port lets a test environment load and read any register and load the condition flags. The multiply itself never alters the flags.

Top module: `mulu_exec`

## Requirements
- R1: In the register form the unit forms the unsigned 64-bit product of the register named by bits [15:11] (the low destination) and the register named by bits [4:0]. The product's bits [63:32] are written to the register named by bits [31:27], and its bits [31:0] to the register named by bits [15:11].
- R2: A word is a register-form multiply exactly when bits [26:16] equal 11'b01000100010 and bits [10:5] equal 6'b111111.
- R3: A word is an immediate-form multiply exactly when bits [26:22] equal 5'b01001, bits [17:16] equal 2'b10 and bits [10:5] equal 6'b111111. Its constant is {bits[21:18], bits[4:0]}, zero-extended to 32 bits, and it replaces the register operand of R1.
- R4: The register named by bits [4:0] keeps its value unless it is also a destination.
- R5: The 5-bit flags output changes only through the test flag load, never by an instruction.
- R6: When bits [31:27] and bits [15:11] name the same register, that register ends up holding the upper 32 bits of the product.
- R7: Register 0 always reads as zero. A result aimed at it is discarded, and the other half is still written.
- R8: After the clock edge that accepts an instruction, busy is high, and done is high for exactly one cycle, the 33rd cycle after that edge. Results are readable after the edge that ends the done cycle, and busy is then low.
- R9: A valid instruction presented while busy is high is ignored: it changes no register and raises no illegal pulse.
- R10: A valid word that is idle-accepted but matches neither encoding raises illegal for exactly the following cycle, does not raise busy, and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word strobe |
| instrWord | input | 32 | Instruction word |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | Results committed at the end of this cycle |
| illegal | output | 1 | One-cycle pulse for an unrecognised word |
| tstWrEn | input | 1 | Test write to the register file |
| tstAddr | input | 5 | Test register address for write and read |
| tstWrData | input | 32 | Test write data |
| tstRdData | output | 32 | Combinational read of register tstAddr |
| tstFlagWrEn | input | 1 | Test load of the flags |
| tstFlagData | input | 5 | Test flag value |
| flags | output | 5 | Condition flags |

## Verification
The assertions take for granted that the test write port is used only while the unit is idle. A test write to a register that is being committed would otherwise be overridden silently. The bench honours this by loading operands only between instructions.

The timing assertion counts cycles from the operand capture, and the product assertion compares against a direct multiply of the captured operands. Both assume the instruction word is stable in the accepting cycle, which the bench guarantees by driving it a half-cycle ahead of each edge. The sweeps cover edge operand values and register aliasing, with expected results computed by 64-bit arithmetic in the bench.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  localparam int InstrW = 32;
  localparam int ImmW   = 9;

  typedef struct packed {
    logic load;
    logic immSel;
    logic step;
    logic commit;
  } ctrlStrb_t;

  function automatic logic isRegForm(input logic [InstrW-1:0] w);
    return (w[26:16] == 11'b01000100010) && (w[10:5] == 6'b111111);
  endfunction

  function automatic logic isImmForm(input logic [InstrW-1:0] w);
    return (w[26:22] == 5'b01001) && (w[17:16] == 2'b10) && (w[10:5] == 6'b111111);
  endfunction
endpackage

// File: rtl/mulu_regfile.sv
module mulu_regfile #(
  parameter int DataW   = 32,
  parameter int NumRegs = 32,
  localparam int AddrW  = $clog2(NumRegs)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] rdAddrA,
  input  logic [AddrW-1:0] rdAddrB,
  input  logic [AddrW-1:0] rdAddrT,
  output logic [DataW-1:0] rdDataA,
  output logic [DataW-1:0] rdDataB,
  output logic [DataW-1:0] rdDataT,
  input  logic             hiEn,
  input  logic [AddrW-1:0] hiAddr,
  input  logic [DataW-1:0] hiData,
  input  logic             loEn,
  input  logic [AddrW-1:0] loAddr,
  input  logic [DataW-1:0] loData,
  input  logic             tstEn,
  input  logic [AddrW-1:0] tstAddr,
  input  logic [DataW-1:0] tstData
);
  logic [DataW-1:0] regQ [NumRegs];

  for (genvar g = 0; g < NumRegs; g++) begin : gReg
    if (g == 0) begin : gZero
      assign regQ[g] = '0;
    end else begin : gStore
      always_ff @(posedge clk) begin
        if (!rstN)                                     regQ[g] <= '0;
        else if (hiEn  && hiAddr  == AddrW'(g))        regQ[g] <= hiData;
        else if (loEn  && loAddr  == AddrW'(g))        regQ[g] <= loData;
        else if (tstEn && tstAddr == AddrW'(g))        regQ[g] <= tstData;
      end
    end
  end

  assign rdDataA = regQ[rdAddrA];
  assign rdDataB = regQ[rdAddrB];
  assign rdDataT = regQ[rdAddrT];

  // R7: the zero register never reports a nonzero value
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrT == '0) |-> (rdDataT == '0));
endmodule

// File: rtl/mulu_ctrl.sv
module mulu_ctrl
  import mulu_pkg::*;
#(
  parameter int DataW = 32,
  localparam int CntW = $clog2(DataW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [InstrW-1:0] instrWord,
  output ctrlStrb_t         strb,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  typedef enum logic [1:0] {Idle, Run, Commit} state_t;
  state_t stateQ;
  logic [CntW-1:0] cntQ;
  logic regHit, immHit, accept;

  assign regHit = isRegForm(instrWord);
  assign immHit = isImmForm(instrWord);
  assign accept = instrValid && (stateQ == Idle);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= Idle;
      cntQ    <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= accept && !regHit && !immHit;
      case (stateQ)
        Idle:   if (accept && (regHit || immHit)) begin
                  stateQ <= Run;
                  cntQ   <= '0;
                end
        Run:    begin
                  cntQ <= cntQ + 1'b1;
                  if (cntQ == CntW'(DataW - 1)) stateQ <= Commit;
                end
        default: stateQ <= Idle;
      endcase
    end
  end

  always_comb begin
    strb.load   = accept && (regHit || immHit);
    strb.immSel = immHit;
    strb.step   = (stateQ == Run);
    strb.commit = (stateQ == Commit);
  end

  assign busy = (stateQ != Idle);
  assign done = strb.commit;

  // Independent cycle count from operand capture, used by the timing check
  logic [7:0] sinceLoad;
  always_ff @(posedge clk) begin
    if (!rstN)                     sinceLoad <= '0;
    else if (strb.load)            sinceLoad <= 8'd1;
    else if (sinceLoad != 8'd0 && sinceLoad != 8'hFF) sinceLoad <= sinceLoad + 1'b1;
  end

  // R8: done appears exactly in the cycle DataW+1 after acceptance
  p_done_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceLoad == 8'(DataW + 1)));
  // R8: busy falls right after the done cycle
  p_done_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);
  // R10: an illegal pulse never coincides with a running operation
  p_illegal_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !busy);
  // R9: a word arriving mid-operation does not restart the count
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && instrValid && !done) |=> busy);
endmodule

// File: rtl/mulu_dp.sv
module mulu_dp
  import mulu_pkg::*;
#(
  parameter int DataW   = 32,
  parameter int NumRegs = 32,
  parameter int FlagW   = 5,
  localparam int AddrW  = $clog2(NumRegs),
  localparam int ProdW  = 2 * DataW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [InstrW-1:0] instrWord,
  output logic [AddrW-1:0]  srcAddrLo,
  output logic [AddrW-1:0]  srcAddrOp,
  input  logic [DataW-1:0]  srcDataLo,
  input  logic [DataW-1:0]  srcDataOp,
  output logic              hiEn,
  output logic [AddrW-1:0]  hiAddr,
  output logic [DataW-1:0]  hiData,
  output logic              loEn,
  output logic [AddrW-1:0]  loAddr,
  output logic [DataW-1:0]  loData,
  input  logic              tstFlagWrEn,
  input  logic [FlagW-1:0]  tstFlagData,
  output logic [FlagW-1:0]  flags
);
  logic [DataW-1:0] mcandQ, mplierQ, opSel;
  logic [ProdW-1:0] prodQ;
  logic [AddrW-1:0] dstHiQ, dstLoQ;
  logic [ImmW-1:0]  imm;
  logic [DataW:0]   partSum;

  assign srcAddrLo = instrWord[15:11];
  assign srcAddrOp = instrWord[4:0];
  assign imm       = {instrWord[21:18], instrWord[4:0]};
  assign opSel     = strb.immSel ? DataW'(imm) : srcDataOp;
  assign partSum   = {1'b0, prodQ[ProdW-1:DataW]} + (prodQ[0] ? {1'b0, mcandQ} : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ  <= '0;
      mplierQ <= '0;
      prodQ   <= '0;
      dstHiQ  <= '0;
      dstLoQ  <= '0;
    end else if (strb.load) begin
      mcandQ  <= srcDataLo;
      mplierQ <= opSel;
      prodQ   <= {{DataW{1'b0}}, opSel};
      dstHiQ  <= instrWord[31:27];
      dstLoQ  <= instrWord[15:11];
    end else if (strb.step) begin
      prodQ   <= {partSum, prodQ[DataW-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            flags <= '0;
    else if (tstFlagWrEn) flags <= tstFlagData;
  end

  assign hiEn   = strb.commit;
  assign hiAddr = dstHiQ;
  assign hiData = prodQ[ProdW-1:DataW];
  assign loEn   = strb.commit;
  assign loAddr = dstLoQ;
  assign loData = prodQ[DataW-1:0];

  // R1: the accumulated product equals the direct multiply of the captured operands
  p_product_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (prodQ == ProdW'(mcandQ) * ProdW'(mplierQ)));
  // R5: flags move only on a test flag load
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tstFlagWrEn |=> $stable(flags));
endmodule

// File: rtl/mulu_exec.sv
module mulu_exec
  import mulu_pkg::*;
#(
  parameter int DataW   = 32,
  parameter int NumRegs = 32,
  parameter int FlagW   = 5,
  localparam int AddrW  = $clog2(NumRegs)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [InstrW-1:0] instrWord,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  input  logic              tstWrEn,
  input  logic [AddrW-1:0]  tstAddr,
  input  logic [DataW-1:0]  tstWrData,
  output logic [DataW-1:0]  tstRdData,
  input  logic              tstFlagWrEn,
  input  logic [FlagW-1:0]  tstFlagData,
  output logic [FlagW-1:0]  flags
);
  ctrlStrb_t        strb;
  logic [AddrW-1:0] srcAddrLo, srcAddrOp, hiAddr, loAddr;
  logic [DataW-1:0] srcDataLo, srcDataOp, hiData, loData;
  logic             hiEn, loEn;

  mulu_ctrl #(.DataW(DataW)) uCtrl (
    .clk, .rstN, .instrValid, .instrWord, .strb, .busy, .done, .illegal
  );

  mulu_dp #(.DataW(DataW), .NumRegs(NumRegs), .FlagW(FlagW)) uDp (
    .clk, .rstN, .strb, .instrWord, .srcAddrLo, .srcAddrOp, .srcDataLo, .srcDataOp,
    .hiEn, .hiAddr, .hiData, .loEn, .loAddr, .loData, .tstFlagWrEn, .tstFlagData, .flags
  );

  mulu_regfile #(.DataW(DataW), .NumRegs(NumRegs)) uRf (
    .clk, .rstN,
    .rdAddrA(srcAddrLo), .rdAddrB(srcAddrOp), .rdAddrT(tstAddr),
    .rdDataA(srcDataLo), .rdDataB(srcDataOp), .rdDataT(tstRdData),
    .hiEn, .hiAddr, .hiData, .loEn, .loAddr, .loData,
    .tstEn(tstWrEn), .tstAddr, .tstData(tstWrData)
  );
endmodule

// File: tb/sim_mulu_exec.sv
module sim_mulu_exec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        busy, done, illegal;
  logic        tstWrEn = 1'b0;
  logic [4:0]  tstAddr = '0;
  logic [31:0] tstWrData = '0;
  logic [31:0] tstRdData;
  logic        tstFlagWrEn = 1'b0;
  logic [4:0]  tstFlagData = '0;
  logic [4:0]  flags;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] model [32];
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;  // 4 ns period

  mulu_exec u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] regWord(input logic [4:0] r3, input logic [4:0] r2, input logic [4:0] r1);
    return {r3, 11'b01000100010, r2, 6'b111111, r1};
  endfunction

  function automatic logic [31:0] immWord(input logic [4:0] r3, input logic [4:0] r2, input logic [8:0] im);
    return {r3, 5'b01001, im[8:5], 2'b10, r2, 6'b111111, im[4:0]};
  endfunction

  function automatic logic [31:0] nextVal();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic setReg(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk);
    tstWrEn = 1'b1; tstAddr = a; tstWrData = v;
    @(negedge clk);
    tstWrEn = 1'b0;
    if (a != 0) model[a] = v;
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 32; i++) begin
      tstAddr = 5'(i);
      #0.1;
      check(req, 64'(tstRdData), 64'(model[i]));
    end
  endtask

  // Issue an instruction, optionally poke a second word mid-run, then apply the expected writes
  task automatic exec(input logic [31:0] w, input logic [4:0] r3, input logic [4:0] r2,
                      input logic [63:0] prod, input bit poke, input logic [31:0] pokeWord);
    int n;
    @(negedge clk);
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0;
    check("R8 busy after accept", 64'(busy), 64'd1);
    n = 1;
    while (!done && n < 100) begin
      if (poke && n == 5) begin instrValid = 1'b1; instrWord = pokeWord; end
      @(negedge clk);
      instrValid = 1'b0;
      if (poke && n == 5) check("R9 no illegal while busy", 64'(illegal), 64'd0);
      n++;
    end
    check("R8 done cycle", 64'(n), 64'd33);
    @(negedge clk);
    check("R8 done single pulse", 64'(done), 64'd0);
    check("R8 busy released", 64'(busy), 64'd0);
    if (r2 != 0) model[r2] = prod[31:0];
    if (r3 != 0) model[r3] = prod[63:32];
  endtask

  task automatic illegalCase(input logic [31:0] w);
    @(negedge clk);
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0;
    check("R10 illegal pulse", 64'(illegal), 64'd1);
    check("R10 not busy", 64'(busy), 64'd0);
    @(negedge clk);
    check("R10 pulse one cycle", 64'(illegal), 64'd0);
    checkAll("R10 registers kept");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] a, b;
    logic [63:0] p;
    logic [8:0]  imms [9] = '{9'd0, 9'd1, 9'h1FF, 9'h100, 9'h0FF, 9'h155, 9'h0AA, 9'h020, 9'h010};
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset busy", 64'(busy), 64'd0);
    check("R8 reset done", 64'(done), 64'd0);
    check("R10 reset illegal", 64'(illegal), 64'd0);
    checkAll("R7 reset registers");

    tstFlagWrEn = 1'b1; tstFlagData = 5'b10110;
    @(negedge clk);
    tstFlagWrEn = 1'b0;

    // R1 R2 R4: register form over edge and generated operands
    for (int i = 0; i < 12; i++) begin
      case (i)
        0: begin a = 32'd0;         b = 32'hFFFF_FFFF; end
        1: begin a = 32'd1;         b = 32'hFFFF_FFFF; end
        2: begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
        3: begin a = 32'h8000_0000; b = 32'h8000_0000; end
        default: begin a = nextVal(); b = nextVal(); end
      endcase
      setReg(5'(1 + i), a);
      setReg(5'(25 + i % 6), b);
      p = 64'(a) * 64'(b);
      exec(regWord(5'(13 + i), 5'(1 + i), 5'(25 + i % 6)), 5'(13 + i), 5'(1 + i), p, 0, 0);
      checkAll("R1 R4 register form");
    end

    // R3: immediate form, constant zero-extended
    for (int i = 0; i < 9; i++) begin
      a = (i < 3) ? 32'hFFFF_FFFF : nextVal();
      setReg(5'd3, a);
      p = 64'(a) * 64'(imms[i]);
      exec(immWord(5'd4, 5'd3, imms[i]), 5'd4, 5'd3, p, 0, 0);
      checkAll("R3 immediate form");
    end

    // R6: both destinations alias, upper half wins
    setReg(5'd5, 32'hDEAD_BEEF); setReg(5'd6, 32'h1357_9BDF);
    p = 64'(32'hDEAD_BEEF) * 64'(32'h1357_9BDF);
    exec(regWord(5'd5, 5'd5, 5'd6), 5'd0, 5'd0, p, 0, 0);
    model[5] = p[63:32];
    checkAll("R6 alias register form");
    setReg(5'd8, 32'hFFFF_0001);
    p = 64'(32'hFFFF_0001) * 64'(9'h1AB);
    exec(immWord(5'd8, 5'd8, 9'h1AB), 5'd0, 5'd0, p, 0, 0);
    model[8] = p[63:32];
    checkAll("R6 alias immediate form");

    // R7: register 0 as upper destination, as source, and as operand
    setReg(5'd9, 32'hCAFE_F00D); setReg(5'd10, 32'h0BAD_1DEA);
    p = 64'(32'hCAFE_F00D) * 64'(32'h0BAD_1DEA);
    exec(regWord(5'd0, 5'd9, 5'd10), 5'd0, 5'd9, p, 0, 0);
    checkAll("R7 zero upper destination");
    exec(regWord(5'd11, 5'd0, 5'd10), 5'd11, 5'd0, 64'd0, 0, 0);
    checkAll("R7 zero source");
    exec(regWord(5'd12, 5'd9, 5'd0), 5'd12, 5'd9, 64'd0, 0, 0);
    checkAll("R7 zero operand");
    setReg(5'd0, 32'h1111_1111);
    checkAll("R7 zero ignores test write");

    // R9: a second instruction during the run is dropped
    setReg(5'd20, 32'h0000_1234); setReg(5'd21, 32'h0000_5678);
    setReg(5'd22, 32'h7777_7777); setReg(5'd23, 32'h3333_3333); setReg(5'd24, 32'hAAAA_5555);
    p = 64'(32'h1234) * 64'(32'h5678);
    exec(regWord(5'd30, 5'd20, 5'd21), 5'd30, 5'd20, p, 1, regWord(5'd24, 5'd22, 5'd23));
    checkAll("R9 busy word ignored");
    p = 64'(32'h0000_1234 * 32'h0000_5678) * 64'(9'h055);
    exec(immWord(5'd31, 5'd20, 9'h055), 5'd31, 5'd20, p, 1, 32'h0);
    checkAll("R9 illegal word while busy ignored");

    // R10 R2 R3: words that miss an encoding by one field
    illegalCase(regWord(5'd2, 5'd3, 5'd4) ^ 32'h0000_0020);
    illegalCase(immWord(5'd2, 5'd3, 9'h0F0) ^ 32'h0001_0000);
    illegalCase(regWord(5'd2, 5'd3, 5'd4) ^ 32'h0400_0000);
    illegalCase(32'h0000_0000);

    check("R5 flags unchanged", 64'(flags), 64'(5'b10110));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule